// File: doc/BRIEF.md
# ULPI Link Bring-Up Sequencer

This block is the link-side controller that takes a ULPI transceiver from power-up to the point where USB traffic may start. It watches the PHY-driven direction and next signals, drives the shared data bus and the stop line, and holds back every receive command until it has reset the PHY itself.

After its own reset it waits for the PHY to release the bus for the first time. It then sends a register write that sets the reset bit of the PHY's function control register, using the set alias of that register. The PHY answers by taking the bus while its internal reset runs and then releasing it. Once that high-then-low pattern of the direction line has been seen, the block raises a ready flag and begins to pass receive commands on. If the PHY takes the bus before the write is accepted, the write is sent again once the bus is free. If the PHY never comes back after the write, a timeout sets an error flag.

Top module: `ulpi_bringup_seq`

## Requirements
- R1: While `rst_n` is low and right after it rises with `dir` high, `ready`, `timeout_err`, `stp`, `data_oe` and `rxcmd_valid` are all 0.
- R2: `data_oe` is 1 only when `dir` is 0 in both the current and the previous cycle. In any cycle when the link drives the bus and no write byte is due, `data_out` is 8'h00. Whenever `data_oe` is 0, `data_out` is 8'h00.
- R3: In a cycle where `dir` differs from its value in the previous cycle, which is a turnaround cycle, `data_oe` is 0.
- R4: Until `ready` is 1, `rxcmd_valid` stays 0 whatever `dir`, `nxt` and `data_in` carry.
- R5: After the first cycle with `dir` low, the link drives the command byte 8'h85 (bits [7:6]=2'b10, bits [5:0]=register address 6'h04 plus 1) on every driven cycle until it samples `nxt` high at a clock edge.
- R6: In the cycle after the edge that accepts the command, `data_out` is 8'h20 (the reset bit). In the cycle after that, `stp` is 1 for exactly one cycle with `data_out` 8'h00.
- R7: If `dir` rises while the command byte is still waiting for `nxt`, nothing is driven while `dir` is high. The command byte 8'h85 is driven again after `dir` falls and the turnaround cycle has passed.
- R8: `ready` rises one cycle after `dir` is sampled low, following a sample of `dir` high that came after the stop cycle. Once set, it stays 1 until reset.
- R9: If `dir` has not gone high and then low again within TIMEOUT_CYCLES clock edges after the stop cycle, `timeout_err` becomes 1 after exactly TIMEOUT_CYCLES edges and stays 1 until reset. This does not stop `ready` from rising later.
- R10: Once `ready` is 1, `rxcmd_valid` is 1 exactly when `dir` is high in both the current and previous cycle and `nxt` is low, and `rxcmd` then equals `data_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | ULPI clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dir | input | 1 | Bus direction from the PHY, 1 = PHY drives |
| nxt | input | 1 | Next/throttle signal from the PHY |
| data_in | input | 8 | Data bus as seen from the PHY side |
| data_out | output | 8 | Data the link drives onto the bus |
| data_oe | output | 1 | Output enable for `data_out` |
| stp | output | 1 | Stop line to the PHY |
| ready | output | 1 | PHY reset finished, traffic may begin |
| timeout_err | output | 1 | PHY did not release the bus after the write |
| rxcmd_valid | output | 1 | A receive command is presented on `rxcmd` |
| rxcmd | output | 8 | Receive command byte |

## Verification
The bench builds the block with TIMEOUT_CYCLES set to 16 rather than 4096. This makes it possible to hold `dir` low after the stop cycle and see the error flag rise on exactly the sixteenth edge, within a short run. It then lets the PHY finish late and confirms that `ready` still rises while the error flag stays set. The same build covers the abort-and-retry path, the turnaround cycles on every change of `dir`, and the point where receive commands start to pass.

// File: rtl/ulpi_bringup_seq.sv
module ulpi_bringup_seq #(
  parameter int unsigned TIMEOUT_CYCLES = 4096,
  parameter logic [5:0]  FUNC_CTRL_ADDR = 6'h04,
  parameter logic [7:0]  RESET_MASK     = 8'h20
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       dir,
  input  logic       nxt,
  input  logic [7:0] data_in,
  output logic [7:0] data_out,
  output logic       data_oe,
  output logic       stp,
  output logic       ready,
  output logic       timeout_err,
  output logic       rxcmd_valid,
  output logic [7:0] rxcmd
);
  localparam logic [7:0] TXCMD_SET = {2'b10, FUNC_CTRL_ADDR + 6'd1};
  localparam int unsigned CW = (TIMEOUT_CYCLES > 2) ? $clog2(TIMEOUT_CYCLES) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(TIMEOUT_CYCLES - 1);

  typedef enum logic [2:0] {
    ST_WREL, ST_SEND, ST_DATA, ST_STP, ST_WHI, ST_WLO, ST_DONE
  } state_t;

  state_t        state;
  logic          dir_q;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) dir_q <= dir;

  wire turnaround = dir ^ dir_q;
  assign data_oe = !dir && !turnaround;

  always_comb begin
    data_out = 8'h00;
    if (data_oe) begin
      if (state == ST_SEND)      data_out = TXCMD_SET;
      else if (state == ST_DATA) data_out = RESET_MASK;
    end
  end

  assign stp         = (state == ST_STP);
  assign ready       = (state == ST_DONE);
  assign rxcmd_valid = ready && dir && dir_q && !nxt;
  assign rxcmd       = data_in;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= ST_WREL;
      cnt         <= '0;
      timeout_err <= 1'b0;
    end else begin
      case (state)
        ST_WREL: if (!dir) state <= ST_SEND;
        ST_SEND: if (data_oe && nxt) state <= ST_DATA;
        ST_DATA: state <= dir ? ST_SEND : ST_STP;
        ST_STP: begin
          state <= ST_WHI;
          cnt   <= '0;
        end
        ST_WHI, ST_WLO: begin
          if (state == ST_WHI && dir)  state <= ST_WLO;
          if (state == ST_WLO && !dir) state <= ST_DONE;
          if (cnt == CNT_LAST) timeout_err <= 1'b1;
          else                 cnt <= cnt + 1'b1;
        end
        default: state <= ST_DONE;
      endcase
    end
  end

  // R3
  turnaround_nodrive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dir != $past(dir)) |-> !data_oe);
  // R4
  rx_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |-> !rxcmd_valid);
  // R6
  stop_follows_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_oe && data_out == RESET_MASK && !stp) |=> stp);
  // R8
  ready_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> ready);
  // R9
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_err |=> timeout_err);
  // R2
  quiet_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !data_oe |-> (data_out == 8'h00));
endmodule

// File: tb/ulpi_bringup_seq_tb.sv
module ulpi_bringup_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int TMO = 16;
  localparam int NV = 19;

  logic clk = 1'b0, rst_n = 1'b0, dir = 1'b1, nxt = 1'b0;
  logic [7:0] data_in = 8'h00;
  logic [7:0] data_out, rxcmd;
  logic data_oe, stp, ready, timeout_err, rxcmd_valid;
  int applied = 0, bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ulpi_bringup_seq #(.TIMEOUT_CYCLES(TMO)) dut_i (
    .clk(clk), .rst_n(rst_n), .dir(dir), .nxt(nxt), .data_in(data_in),
    .data_out(data_out), .data_oe(data_oe), .stp(stp), .ready(ready),
    .timeout_err(timeout_err), .rxcmd_valid(rxcmd_valid), .rxcmd(rxcmd));

  // {dir, nxt, data_in, exp data_oe, exp data_out, exp stp, exp ready, exp rxcmd_valid}
  localparam logic [21:0] VEC [NV] = '{
    {1'b1,1'b0,8'h4A, 1'b0,8'h00,1'b0,1'b0,1'b0},
    {1'b0,1'b0,8'h00, 1'b0,8'h00,1'b0,1'b0,1'b0},
    {1'b0,1'b0,8'h00, 1'b1,8'h85,1'b0,1'b0,1'b0},
    {1'b1,1'b0,8'h00, 1'b0,8'h00,1'b0,1'b0,1'b0},
    {1'b1,1'b0,8'h33, 1'b0,8'h00,1'b0,1'b0,1'b0},
    {1'b0,1'b0,8'h00, 1'b0,8'h00,1'b0,1'b0,1'b0},
    {1'b0,1'b0,8'h00, 1'b1,8'h85,1'b0,1'b0,1'b0},
    {1'b0,1'b1,8'h00, 1'b1,8'h85,1'b0,1'b0,1'b0},
    {1'b0,1'b0,8'h00, 1'b1,8'h20,1'b0,1'b0,1'b0},
    {1'b0,1'b0,8'h00, 1'b1,8'h00,1'b1,1'b0,1'b0},
    {1'b0,1'b0,8'h00, 1'b1,8'h00,1'b0,1'b0,1'b0},
    {1'b1,1'b0,8'h00, 1'b0,8'h00,1'b0,1'b0,1'b0},
    {1'b1,1'b0,8'h55, 1'b0,8'h00,1'b0,1'b0,1'b0},
    {1'b0,1'b0,8'h00, 1'b0,8'h00,1'b0,1'b0,1'b0},
    {1'b0,1'b0,8'h00, 1'b1,8'h00,1'b0,1'b1,1'b0},
    {1'b1,1'b0,8'h00, 1'b0,8'h00,1'b0,1'b1,1'b0},
    {1'b1,1'b0,8'h4C, 1'b0,8'h00,1'b0,1'b1,1'b1},
    {1'b1,1'b1,8'h11, 1'b0,8'h00,1'b0,1'b1,1'b0},
    {1'b0,1'b0,8'h00, 1'b0,8'h00,1'b0,1'b1,1'b0}
  };
  // requirement each vector targets: R4 R3 R5 R7 R4 R3 R7 R5 R6 R6 R2 R3 R4 R8 R8 R10 R10 R10 R8
  localparam int VREQ [NV] = '{4,3,5,7,4,3,7,5,6,6,2,3,4,8,8,10,10,10,8};

  task automatic apply(input logic d, input logic n, input logic [7:0] din);
    @(negedge clk);
    dir = d; nxt = n; data_in = din;
    #1;
  endtask

  task automatic check(input int req, input string what, input logic [7:0] act, input logic [7:0] exp);
    applied++;
    if (act !== exp) begin
      bad++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    $display("FAIL R0 watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(posedge clk);
    #1;
    check(1, "ready in reset", {7'd0, ready}, 8'h00);
    check(1, "err in reset", {7'd0, timeout_err}, 8'h00);
    @(negedge clk); rst_n = 1'b1; #1;
    check(1, "stp after reset", {7'd0, stp}, 8'h00);
    check(1, "oe after reset", {7'd0, data_oe}, 8'h00);
    check(1, "rxv after reset", {7'd0, rxcmd_valid}, 8'h00);

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][21], VEC[i][20], VEC[i][19:12]);
      check(VREQ[i], "data_oe", {7'd0, data_oe}, {7'd0, VEC[i][11]});
      check(VREQ[i], "data_out", data_out, VEC[i][10:3]);
      check(VREQ[i], "stp", {7'd0, stp}, {7'd0, VEC[i][2]});
      check(VREQ[i], "ready", {7'd0, ready}, {7'd0, VEC[i][1]});
      check(VREQ[i], "rxcmd_valid", {7'd0, rxcmd_valid}, {7'd0, VEC[i][0]});
      if (VEC[i][0]) check(10, "rxcmd", rxcmd, VEC[i][19:12]);
      check(9, "no timeout", {7'd0, timeout_err}, 8'h00);
    end

    // R9: timeout directed test
    @(negedge clk); rst_n = 1'b0; dir = 1'b1; nxt = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    apply(0, 0, 8'h00);
    apply(0, 1, 8'h00);
    check(5, "cmd before accept", data_out, 8'h85);
    apply(0, 0, 8'h00);
    check(6, "reset byte", data_out, 8'h20);
    apply(0, 0, 8'h00);
    check(6, "stop pulse", {7'd0, stp}, 8'h01);
    for (int k = 1; k <= TMO; k++) begin
      apply(0, 0, 8'h00);
      if (k == 2) check(6, "stop one cycle", {7'd0, stp}, 8'h00);
      check(9, "err before limit", {7'd0, timeout_err}, 8'h00);
    end
    apply(0, 0, 8'h00);
    check(9, "err at limit", {7'd0, timeout_err}, 8'h01);
    apply(1, 0, 8'h00);
    apply(1, 0, 8'h00);
    apply(0, 0, 8'h00);
    check(8, "not ready during turnaround edge", {7'd0, ready}, 8'h00);
    apply(0, 0, 8'h00);
    check(8, "late ready", {7'd0, ready}, 8'h01);
    check(9, "err sticky", {7'd0, timeout_err}, 8'h01);
    apply(1, 0, 8'h00);
    apply(1, 0, 8'h9A);
    check(10, "rxcmd after late ready", {7'd0, rxcmd_valid}, 8'h01);
    check(10, "rxcmd value", rxcmd, 8'h9A);

    $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
    $finish;
  end
endmodule